// File: doc/BRIEF.md
# Bridge Reset and Power-State Sequencer

This block decides when a two-port bus bridge is held in reset, when its bus drivers may drive, and when configuration cycles may be accepted. An active-high primary reset that may arrive at any time turns off both sides' output enables at once, with no clock needed. Its release reaches the internal logic through a two-stage synchroniser. After every internal reset, a hold-off counter keeps configuration access refused for a fixed number of clocks.

The block keeps the secondary-reset control bit itself. That bit is written by configuration writes and holds the downstream bus in reset until software clears it. A requested power state drives a small state machine. Leaving the hot low-power state for the full-power state runs a short internal soft reset and does not reset the downstream bus. Leaving the powered-off state runs a full power-up style reset, which also resets the downstream bus.

Top module: `brg_rst_seq`

## Requirements
- R1: While `prim_rst` is high, `pri_oe` and `sec_oe` are low at once, with no clock edge needed.
- R2: While `prim_rst` is high and clocks run, `chip_rst` and `buf_clr` are high and `cfg_rdy` is low. The secondary-reset bit returns to 0.
- R3: After `prim_rst` falls, `chip_rst` stays high through the first rising clock edge and drops after the second.
- R4: `cfg_rdy` is low during any internal reset. It rises only after HOLD_CLKS (default 16) clocks with `chip_rst` low: after the 18th rising edge following a primary reset release.
- R5: `sec_bus_rst` is high whenever `prim_rst` is high, including before any clock edge.
- R6: A configuration write (`cfg_wr` high while `cfg_rdy` is high) loads bit SRST_POS (default 6) of `cfg_wdata` into the secondary-reset bit. While that bit is 1, `sec_bus_rst` stays high. Only a write with that bit 0, or an internal reset, releases it.
- R7: `sec_oe` is low whenever `sec_bus_rst` is high.
- R8: `pwr_req` encoding: 2'b00 full power, 2'b11 hot low-power, 2'b10 powered off, 2'b01 ignored. In hot low-power, all `sclk_en` bits are low and `cfg_rdy` keeps its value.
- R9: From hot low-power to full power, `chip_rst` and `buf_clr` are high for SOFT_CLKS (default 2) clocks and `sclk_en` returns high. `sec_bus_rst` is not raised, the secondary-reset bit is cleared, and the R4 hold-off repeats.
- R10: Powered off holds `chip_rst`, `buf_clr` and `sec_bus_rst` high and both output enables low. Returning to full power keeps `chip_rst` and `sec_bus_rst` high for SOFT_CLKS clocks, then repeats the R4 hold-off.
- R11: A configuration write while `cfg_rdy` is low has no effect on the secondary-reset bit.
- R12: In the powered-off state, a request for hot low-power is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary bus clock |
| prim_rst | input | 1 | Primary reset, active high, asynchronous both ways |
| cfg_wr | input | 1 | Configuration write strobe to the bridge control register |
| cfg_wdata | input | DW | Configuration write data |
| pwr_req | input | 2 | Requested power state |
| chip_rst | output | 1 | Internal chip reset |
| sec_bus_rst | output | 1 | Secondary bus reset, active high |
| sclk_en | output | NCLK | Secondary clock output enables |
| pri_oe | output | 1 | Primary interface output enable |
| sec_oe | output | 1 | Secondary interface output enable, grants included |
| buf_clr | output | 1 | Clear for all posting buffers |
| cfg_rdy | output | 1 | Configuration access allowed |

## Verification
The assertions take for granted that `pwr_req` and `cfg_wr` change only away from the rising clock edge. They also assume `prim_rst` is high from time zero, so the disabled-while-reset properties start from a known state. The stimulus drives every synchronous input on the falling edge. It raises `prim_rst` asynchronously only at a point midway between edges, and it changes `pwr_req` only after any soft or cold reset pulse has finished.

// File: rtl/brg_rst_pkg.sv
package brg_rst_pkg;
  typedef enum logic [1:0] {
    PW_D0     = 2'b00,
    PW_RSVD   = 2'b01,
    PW_D3COLD = 2'b10,
    PW_D3HOT  = 2'b11
  } pwr_e;
endpackage

// File: rtl/brg_rst_sync.sv
module brg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_s
);
  logic [STAGES-1:0] sh;

  // assert immediately, release after STAGES rising edges
  always_ff @(posedge clk or posedge arst) begin
    if (arst) sh <= '1;
    else      sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign rst_s = sh[STAGES-1];
endmodule

// File: rtl/brg_pwr_fsm.sv
module brg_pwr_fsm
  import brg_rst_pkg::*;
#(
  parameter int SOFT_CLKS = 2
) (
  input  logic clk,
  input  logic rst_s,
  input  pwr_e req,
  output pwr_e st,
  output logic soft_act,
  output logic cold_act
);
  localparam int PW = $clog2(SOFT_CLKS + 1);

  logic [PW-1:0] pcnt;
  logic          cold_q;

  always_ff @(posedge clk or posedge rst_s) begin
    if (rst_s) begin
      st     <= PW_D0;
      pcnt   <= '0;
      cold_q <= 1'b0;
    end else if (pcnt != '0) begin
      pcnt <= pcnt - 1'b1;
    end else begin
      case (st)
        PW_D0: begin
          if (req == PW_D3HOT)       st <= PW_D3HOT;
          else if (req == PW_D3COLD) st <= PW_D3COLD;
        end
        PW_D3HOT: begin
          if (req == PW_D0) begin
            st     <= PW_D0;
            pcnt   <= PW'(SOFT_CLKS);
            cold_q <= 1'b0;
          end else if (req == PW_D3COLD) begin
            st <= PW_D3COLD;
          end
        end
        PW_D3COLD: begin
          if (req == PW_D0) begin
            st     <= PW_D0;
            pcnt   <= PW'(SOFT_CLKS);
            cold_q <= 1'b1;
          end
        end
        default: st <= PW_D0;
      endcase
    end
  end

  assign soft_act = (pcnt != '0) && !cold_q;
  assign cold_act = (pcnt != '0) &&  cold_q;
endmodule

// File: rtl/brg_rdy_cnt.sv
module brg_rdy_cnt #(
  parameter int HOLD_CLKS = 16
) (
  input  logic clk,
  input  logic rst_s,
  input  logic clr,
  output logic done
);
  localparam int CW = $clog2(HOLD_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge rst_s) begin
    if (rst_s)                     cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (cnt != CW'(HOLD_CLKS)) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == CW'(HOLD_CLKS));
endmodule

// File: rtl/brg_rst_seq.sv
module brg_rst_seq
  import brg_rst_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SRST_POS  = 6,
  parameter int HOLD_CLKS = 16,
  parameter int SOFT_CLKS = 2,
  parameter int NCLK      = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic            clk,
  input  logic            prim_rst,
  input  logic            cfg_wr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [1:0]      pwr_req,
  output logic            chip_rst,
  output logic            sec_bus_rst,
  output logic [NCLK-1:0] sclk_en,
  output logic            pri_oe,
  output logic            sec_oe,
  output logic            buf_clr,
  output logic            cfg_rdy
);
  logic rst_s;
  pwr_e st;
  logic soft_act, cold_act, cnt_done;
  logic in_cold, srst_q;
  logic unused_wdata;

  brg_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .arst (prim_rst),
    .rst_s(rst_s)
  );

  brg_pwr_fsm #(.SOFT_CLKS(SOFT_CLKS)) u_fsm (
    .clk     (clk),
    .rst_s   (rst_s),
    .req     (pwr_e'(pwr_req)),
    .st      (st),
    .soft_act(soft_act),
    .cold_act(cold_act)
  );

  assign in_cold = (st == PW_D3COLD);

  brg_rdy_cnt #(.HOLD_CLKS(HOLD_CLKS)) u_rdy (
    .clk  (clk),
    .rst_s(rst_s),
    .clr  (soft_act | cold_act | in_cold),
    .done (cnt_done)
  );

  // secondary-reset control bit
  always_ff @(posedge clk or posedge rst_s) begin
    if (rst_s)                              srst_q <= 1'b0;
    else if (soft_act | cold_act | in_cold) srst_q <= 1'b0;
    else if (cfg_wr && cfg_rdy)             srst_q <= cfg_wdata[SRST_POS];
  end

  assign unused_wdata = ^cfg_wdata;

  assign chip_rst    = rst_s | soft_act | cold_act | in_cold;
  assign buf_clr     = chip_rst;
  assign sec_bus_rst = prim_rst | rst_s | srst_q | in_cold | cold_act;
  assign pri_oe      = !prim_rst && !chip_rst;
  assign sec_oe      = pri_oe && !sec_bus_rst;
  assign cfg_rdy     = cnt_done && !chip_rst;
  assign sclk_en     = {NCLK{st == PW_D0}};
endmodule

// File: rtl/brg_rst_seq_chk.sv
module brg_rst_seq_chk #(
  parameter int HOLD_CLKS = 16,
  parameter int NCLK      = 4
) (
  input logic            clk,
  input logic            prim_rst,
  input logic            cfg_wr,
  input logic            chip_rst,
  input logic            sec_bus_rst,
  input logic [NCLK-1:0] sclk_en,
  input logic            pri_oe,
  input logic            sec_oe,
  input logic            cfg_rdy
);
  localparam int CW = $clog2(HOLD_CLKS + 1);

  logic [CW-1:0] quiet;

  // clocks since the last internal reset, saturating
  always_ff @(posedge clk or posedge prim_rst) begin
    if (prim_rst)                     quiet <= '0;
    else if (chip_rst)                quiet <= '0;
    else if (quiet != CW'(HOLD_CLKS)) quiet <= quiet + 1'b1;
  end

  // R1
  oe_off_in_reset_chk: assert property (@(posedge clk)
    prim_rst |-> (!pri_oe && !sec_oe && sec_bus_rst));

  // R4
  rdy_after_hold_chk: assert property (@(posedge clk) disable iff (prim_rst)
    cfg_rdy |-> (quiet == CW'(HOLD_CLKS)));

  // R4
  rdy_not_in_reset_chk: assert property (@(posedge clk) disable iff (prim_rst)
    cfg_rdy |-> !chip_rst);

  // R6
  srst_release_cause_chk: assert property (@(posedge clk) disable iff (prim_rst)
    $fell(sec_bus_rst) |-> ($past(cfg_wr) || $past(chip_rst)));

  // R7
  sec_oe_gated_chk: assert property (@(posedge clk) disable iff (prim_rst)
    sec_oe |-> !sec_bus_rst);

  // R9
  soft_wake_quiet_chk: assert property (@(posedge clk) disable iff (prim_rst)
    ($rose(sclk_en[0]) && chip_rst && !$past(sec_bus_rst)) |-> !sec_bus_rst);
endmodule

bind brg_rst_seq brg_rst_seq_chk #(.HOLD_CLKS(HOLD_CLKS), .NCLK(NCLK)) u_chk (
  .clk        (clk),
  .prim_rst   (prim_rst),
  .cfg_wr     (cfg_wr),
  .chip_rst   (chip_rst),
  .sec_bus_rst(sec_bus_rst),
  .sclk_en    (sclk_en),
  .pri_oe     (pri_oe),
  .sec_oe     (sec_oe),
  .cfg_rdy    (cfg_rdy)
);

// File: tb/tb_brg_rst_seq.sv
`timescale 1ns/1ps
module tb_brg_rst_seq;
  localparam int DW = 16;
  localparam int NCLK = 4;

  logic            clk = 1'b0;
  logic            prim_rst = 1'b1;
  logic            cfg_wr = 1'b0;
  logic [DW-1:0]   cfg_wdata = '0;
  logic [1:0]      pwr_req = 2'b00;
  logic            chip_rst, sec_bus_rst, pri_oe, sec_oe, buf_clr, cfg_rdy;
  logic [NCLK-1:0] sclk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      rq;
    logic [6:0] exp;
    logic [6:0] msk;
  } item_t;
  item_t q[$];

  brg_rst_seq #(.DW(DW), .NCLK(NCLK)) dut (
    .clk(clk), .prim_rst(prim_rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pwr_req(pwr_req), .chip_rst(chip_rst), .sec_bus_rst(sec_bus_rst),
    .sclk_en(sclk_en), .pri_oe(pri_oe), .sec_oe(sec_oe), .buf_clr(buf_clr),
    .cfg_rdy(cfg_rdy)
  );

  always #4 clk = ~clk;

  // observed vector: [6]pri_oe [5]sec_oe [4]sec_bus_rst [3]chip_rst
  //                  [2]buf_clr [1]cfg_rdy [0]sclk_en[0]
  function automatic logic [6:0] obs();
    return {pri_oe, sec_oe, sec_bus_rst, chip_rst, buf_clr, cfg_rdy, sclk_en[0]};
  endfunction

  task automatic compare(string rq, logic [6:0] e, logic [6:0] m);
    checks++;
    if ((obs() & m) !== (e & m)) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b mask=%b", rq, obs(), e, m);
    end
  endtask

  task automatic push(string rq, logic [6:0] e, logic [6:0] m);
    item_t it;
    it.rq = rq; it.exp = e; it.msk = m;
    q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(logic [DW-1:0] d);
    cfg_wdata = d;
    cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops expected items just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        compare(it.rq, it.exp, it.msk);
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    #1;
    compare("R1 R5 before clock", 7'b0010000, 7'b1110000);
    tick(3);
    push("R2 held reset", 7'b0011100, 7'b1111110);

    prim_rst = 1'b0;
    tick(1);
    push("R3 sync stage 1", 7'b0001000, 7'b0001000);
    tick(1);
    push("R3 released", 7'b1100001, 7'b1111111);
    tick(15);
    push("R4 edge 17 not ready", 7'b0000000, 7'b0000010);
    tick(1);
    push("R4 edge 18 ready", 7'b1100011, 7'b1111111);

    cfg_write(16'h0040);
    push("R6 R7 srst set", 7'b1010000, 7'b1110000);
    tick(4);
    push("R6 srst held", 7'b1010000, 7'b1110000);
    cfg_write(16'hFFBF);
    push("R6 srst cleared", 7'b1100000, 7'b1110000);

    pwr_req = 2'b11;
    tick(1);
    push("R8 hot clocks off", 7'b0000010, 7'b0001011);
    pwr_req = 2'b01;
    tick(2);
    push("R8 reserved ignored", 7'b0000010, 7'b0001011);

    pwr_req = 2'b00;
    tick(1);
    push("R9 soft reset", 7'b0001101, 7'b1111111);
    tick(1);
    push("R9 soft reset 2nd", 7'b0001101, 7'b1111111);
    tick(1);
    push("R9 soft done", 7'b1100001, 7'b1111111);
    cfg_write(16'h0040);
    push("R11 write ignored", 7'b0000000, 7'b0010000);
    tick(14);
    push("R9 holdoff edge 17", 7'b0000000, 7'b0000010);
    tick(1);
    push("R9 holdoff edge 18", 7'b1100011, 7'b1111111);

    cfg_write(16'h0040);
    push("R6 srst set again", 7'b0010000, 7'b0010000);
    pwr_req = 2'b11;
    tick(1);
    pwr_req = 2'b00;
    tick(1);
    push("R9 wake with srst", 7'b0001001, 7'b0001001);
    tick(1);
    push("R9 srst cleared", 7'b0000000, 7'b0010000);
    tick(17);
    push("R9 ready again", 7'b1100011, 7'b1111111);

    pwr_req = 2'b10;
    tick(1);
    push("R10 powered off", 7'b0011100, 7'b1111111);
    pwr_req = 2'b11;
    tick(2);
    push("R12 hot ignored", 7'b0011100, 7'b1111111);
    pwr_req = 2'b00;
    tick(1);
    push("R10 cold wake", 7'b0011101, 7'b1111111);
    tick(2);
    push("R10 cold done", 7'b1100001, 7'b1111111);
    tick(16);
    push("R10 ready", 7'b1100011, 7'b1111111);

    tick(1);
    #2;
    prim_rst = 1'b1;
    #1;
    compare("R1 R5 async assert", 7'b0010000, 7'b1110000);
    tick(2);
    push("R2 reset again", 7'b0011101, 7'b1111111);
    tick(1);
    #2;
    summary();
  end
endmodule